// File: doc/BRIEF.md
# Pulse-and-Verify Memory Programming Sequencer

This block writes an address range of a one-time or light-erasable 16-bit memory. For each address it takes the target word from a data source that looks at the current address. It drives all 16 bits in parallel and applies program strobes of a fixed width. After every strobe it reads the location back. It stops pulsing an address as soon as the read-back matches. If the read-back still differs after a set number of pulses, the address has failed. Addresses are handled in ascending order from the first address to the last. A word of all ones is the erased state, so it gets no pulses.

All strobes and all per-address reads happen while a raised-supply request is held. Once the last address passes, the block drops that request and raises a normal-supply request. It then reads back every address of the range once more. The first mismatch in either phase ends the run, raises the failure flag and keeps the offending address. If both phases pass, the block raises done instead. A new start pulse in the idle, done or failed state begins a fresh run.

Top module: `pulse_verify_prog`

## Requirements
- R1: After reset the program strobe `prog_n` and the read enable `oe_n` are high (inactive), both supply requests are low, and `done` and `fail` are low.
- R2: Each program strobe holds `prog_n` low for exactly PULSE_CYC clock cycles. During a strobe `oe_n` is high and `hv_req` is high.
- R3: `prog_n` and `oe_n` are never low together. After every strobe a read with `oe_n` low and `prog_n` high compares `mem_rdata` against the source word.
- R4: An address whose word verifies after k pulses receives exactly k pulses, for any k up to and including MAX_PULSES. The block then moves to the next address.
- R5: If an address still mismatches after MAX_PULSES pulses, the run stops with `fail` high and `fail_addr` equal to that address. Higher addresses get no pulses.
- R6: An address whose source word is 16'hFFFF receives zero pulses.
- R7: Pulses are applied only to addresses from `first_addr` to `last_addr`, in ascending order. During a strobe, `mem_wdata` carries the source word for `mem_addr`.
- R8: After the last address passes, every address from `first_addr` to `last_addr` is read once with `nv_req` high and `hv_req` low. A mismatch sets `fail` and sets `fail_addr` to that address.
- R9: `done` rises only after both phases pass. `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle, done or failed |
| first_addr | input | AW | Lowest address of the range |
| last_addr | input | AW | Highest address of the range |
| src_word | input | 16 | Target word for the current `mem_addr` |
| mem_rdata | input | 16 | Read-back data from the memory |
| mem_addr | output | AW | Memory address (also indexes the data source) |
| mem_wdata | output | 16 | Data applied during programming |
| prog_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | Read enable, active low |
| hv_req | output | 1 | Raised-supply mode request |
| nv_req | output | 1 | Normal-supply mode request |
| done | output | 1 | Both phases passed |
| fail | output | 1 | A phase failed |
| fail_addr | output | AW | Address that failed |

## Verification
The bench uses a memory model. In this model each location needs its own random number of pulses before it takes the word, and some words are all ones, so the pulse count per address shows whether pulsing stops at the first match. One location needs exactly the pulse limit and another needs one pulse more; together they separate an off-by-one limit from a correct one. A location that reads correctly under the raised supply but wrongly under the normal supply can only be caught by the final pass. A single-address range and full-range random runs check range handling and order.

// File: rtl/pulse_verify_prog.sv
module pulse_verify_prog #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int PULSE_CYC  = 12500,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  input  logic [DW-1:0] src_word,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          prog_n,
  output logic          oe_n,
  output logic          hv_req,
  output logic          nv_req,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int TW = $clog2(PULSE_CYC + 1);
  localparam int CW = $clog2(MAX_PULSES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_PULSE, S_READ, S_ADV, S_VER, S_DONE, S_FAIL
  } state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] pcnt;

  wire match     = (mem_rdata == src_word);
  wire at_last   = (addr == last_addr);
  wire pulse_end = (tcnt == TW'(PULSE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr      <= '0;
      tcnt      <= '0;
      pcnt      <= '0;
      fail_addr <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            addr      <= first_addr;
            fail_addr <= '0;
            state     <= S_LOAD;
          end
        S_LOAD: begin
          tcnt  <= '0;
          pcnt  <= '0;
          state <= (src_word == '1) ? S_ADV : S_PULSE;
        end
        S_PULSE:
          if (pulse_end) begin
            tcnt  <= '0;
            pcnt  <= pcnt + 1'b1;
            state <= S_READ;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        S_READ:
          if (match) state <= S_ADV;
          else if (pcnt == CW'(MAX_PULSES)) begin
            fail_addr <= addr;
            state     <= S_FAIL;
          end else state <= S_PULSE;
        S_ADV:
          if (at_last) begin
            addr  <= first_addr;
            state <= S_VER;
          end else begin
            addr  <= addr + 1'b1;
            state <= S_LOAD;
          end
        S_VER:
          if (!match) begin
            fail_addr <= addr;
            state     <= S_FAIL;
          end else if (at_last) state <= S_DONE;
          else addr <= addr + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr;
  assign mem_wdata = src_word;
  assign prog_n    = (state != S_PULSE);
  assign oe_n      = !(state == S_READ || state == S_VER);
  assign hv_req    = (state == S_LOAD || state == S_PULSE || state == S_READ || state == S_ADV);
  assign nv_req    = (state == S_VER);
  assign done      = (state == S_DONE);
  assign fail      = (state == S_FAIL);

  // R2
  strobe_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (hv_req && oe_n));
  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!prog_n && !oe_n));
  // R3
  read_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> !oe_n);
  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= CW'(MAX_PULSES));
  // R8
  supply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_req && nv_req));
  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R9
  done_after_ver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(nv_req));
endmodule

// File: tb/pulse_verify_prog_bench.sv
module pulse_verify_prog_bench;
  localparam int AW = 5, DW = 16, P = 4, MAXP = 25, N = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic [DW-1:0] src_word, mem_rdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata;
  logic prog_n, oe_n, hv_req, nv_req, done, fail;

  always #4 clk = ~clk;

  pulse_verify_prog #(.AW(AW), .DW(DW), .PULSE_CYC(P), .MAX_PULSES(MAXP)) u_pulse_verify_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .src_word(src_word), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .prog_n(prog_n), .oe_n(oe_n), .hv_req(hv_req), .nv_req(nv_req), .done(done),
    .fail(fail), .fail_addr(fail_addr));

  logic [DW-1:0] src [N];
  logic [DW-1:0] mem [N];
  int need [N];
  int pcount [N];
  bit seen_ver [N];
  int marg = -1;
  int errors = 0, checks = 0;
  bit active = 0, prev_prog = 1;
  int lowcnt = 0, last_pa = -1, pa = 0;

  assign src_word = src[mem_addr];
  always_comb begin
    mem_rdata = '1;
    if (!oe_n) begin
      mem_rdata = mem[mem_addr];
      if (nv_req && int'(mem_addr) == marg) mem_rdata = mem_rdata ^ 16'h0001;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(int a);
    if (src[a] == '1) return 0;
    return (need[a] > MAXP) ? MAXP : need[a];
  endfunction

  always @(negedge clk) if (active) begin
    if (!prog_n) begin
      if (prev_prog) begin
        pa = int'(mem_addr);
        chk(pa >= last_pa, "R7 order", pa, last_pa);
        chk(mem_wdata == src[pa], "R7 wdata", int'(mem_wdata), int'(src[pa]));
        chk(hv_req && oe_n, "R2 hv/oe", {hv_req, oe_n}, 3);
        last_pa = pa;
      end
      lowcnt++;
    end else if (!prev_prog) begin
      chk(lowcnt == P, "R2 width", lowcnt, P);
      lowcnt = 0;
      pcount[pa]++;
      if (pcount[pa] >= need[pa]) mem[pa] = mem[pa] & src[pa];
    end
    if (!oe_n && nv_req) begin
      seen_ver[mem_addr] = 1;
      if (hv_req) chk(0, "R8 hv in verify", 1, 0);
    end
    prev_prog = prog_n;
  end

  task automatic run(int f, int l);
    int fa = -1, cyc = 0;
    bit exp_fail = 0;
    for (int a = 0; a < N; a++) begin
      mem[a] = '1; pcount[a] = 0; seen_ver[a] = 0;
    end
    last_pa = -1; lowcnt = 0; prev_prog = 1;
    @(negedge clk);
    first_addr = AW'(f); last_addr = AW'(l); start = 1; active = 1;
    @(negedge clk);
    start = 0;
    while (!(done || fail) && cyc < 50000) begin @(negedge clk); cyc++; end
    active = 0;
    if (cyc >= 50000) chk(0, "watchdog", cyc, 0);
    for (int a = f; a <= l; a++)
      if (src[a] != '1 && need[a] > MAXP) begin fa = a; exp_fail = 1; break; end
    if (!exp_fail && marg >= f && marg <= l) begin fa = marg; exp_fail = 1; end
    chk(fail == exp_fail, "R5/R8 fail flag", fail, exp_fail);
    chk(done == !exp_fail, "R9 done flag", done, !exp_fail);
    if (exp_fail) chk(int'(fail_addr) == fa, "R5/R8 fail_addr", fail_addr, fa);
    for (int a = 0; a < N; a++) begin
      int e = 0;
      bit reached = (a >= f && a <= l) &&
                    !(exp_fail && fa == a - 0 && 0) && !(exp_fail && fa < a && fa != marg);
      if (reached) e = exp_pulses(a);
      if (a < f || a > l) chk(pcount[a] == 0, "R7 out of range", pcount[a], 0);
      else if (src[a] == '1) chk(pcount[a] == 0, "R6 all-ones", pcount[a], 0);
      else chk(pcount[a] == e, "R4/R5 pulses", pcount[a], e);
      if (done && a >= f && a <= l) chk(seen_ver[a], "R8 final read", seen_ver[a], 1);
    end
  endtask

  task automatic fill(int lo, int hi);
    for (int a = lo; a <= hi; a++) begin
      src[a]  = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      if (src[a] == 16'hFFFF && $urandom % 2 == 0) src[a] = 16'h0000;
      need[a] = 1 + $urandom % 6;
    end
  endtask

  initial begin
    int unsigned seed = $urandom(32'd7);
    fill(0, N - 1);
    #1;
    chk(prog_n && oe_n && !hv_req && !nv_req && !done && !fail, "R1 reset",
        {prog_n, oe_n, hv_req, nv_req, done, fail}, 6'b110000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(prog_n && oe_n && !done && !fail, "R1 idle", {prog_n, oe_n, done, fail}, 4'b1100);
    src[2] = 16'hFFFF;
    run(0, 15);
    fill(0, N - 1); need[5] = MAXP; src[5] = 16'h1234;
    run(3, 8);
    fill(0, N - 1); need[10] = MAXP + 1; src[10] = 16'h0F0F;
    run(8, 12);
    fill(0, N - 1); marg = 20; src[20] = 16'hA5A4;
    run(18, 22);
    marg = -1;
    fill(0, N - 1);
    run(31, 31);
    fill(0, N - 1);
    run(0, 31);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule